// File: doc/BRIEF.md
# Serial video receive NRZI decoder and descrambler

This block sits behind the deserializer of a serial digital video receiver. Each clock it takes one parallel receive word and reverses the two line codings applied by the transmitter. It first removes the NRZI transition coding. It then strips the self-synchronizing scrambling defined by the generator x^9 + x^4 + 1. Bits are taken in the order they came off the wire, least significant bit first. Both codings carry their history across word boundaries, so the stream behaves as one continuous bit sequence.

A rate-select input chooses the word width. High-definition rate uses all 20 bits. Standard-definition rate uses only the low 10 bits. The same state machinery serves both rates, and state carries over when the rate changes. A valid input qualifies each word. Idle cycles leave the history unchanged. The result appears one clock later and is still unaligned. A separate word aligner downstream finds the word boundaries.

Top module: `sdi_rx_descrambler`

## Requirements
- R1: While `rst_n` is low, `dout` is zero, `dout_vld` is low, and both the NRZI history bit and the nine-bit descrambler history are zero. As a result, an all-ones 20-bit word accepted right after reset produces `dout` = 0x00211.
- R2: `dout_vld` equals the `din_vld` of the previous clock. A valid word's result appears on `dout` exactly one clock after the word is presented.
- R3: Each NRZI-decoded bit is the received bit XOR the received bit before it, in LSB-first order. For bit 0 of a word, the earlier bit is the last used bit of the previous valid word.
- R4: Each output bit is the decoded bit XOR the decoded bits 4 and 9 positions earlier in the continuous LSB-first stream. That history crosses word boundaries.
- R5: With `hd_mode` = 1, all 20 bits of `din` are processed, with bit 0 first and bit 19 last.
- R6: With `hd_mode` = 0, only `din[9:0]` is processed and `din[19:10]` has no effect. `dout[19:10]` is driven to zero, and bit 9 supplies the history for the next word.
- R7: A clock with `din_vld` = 0 changes no history. `dout` keeps its previous value and `dout_vld` goes low.
- R8: When `hd_mode` changes between valid words, decoding continues from the carried history without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| hd_mode | input | 1 | 1 = 20-bit high-definition word, 0 = 10-bit standard-definition word |
| din_vld | input | 1 | Qualifies `din` this cycle |
| din | input | 20 | Raw NRZI-coded, scrambled receive word, LSB earliest |
| dout_vld | output | 1 | Registered copy of `din_vld` |
| dout | output | 20 | Decoded, descrambled, unaligned word |

## Verification
The case most likely to fail is a word that both switches rate and is the first valid word after an idle gap. Two things must then happen together. The width selection decides which input bit becomes the next NRZI reference. The held history from before the gap must also feed bit 0 of the new word. The stimulus table places rate switches directly after invalid words that carry junk data. A bit-serial reference model, fed only on valid words, must match every output word. Any history taken from the wrong bit position, or any history changed during the gap, shows up as a data mismatch on the following word.

// File: rtl/sdi_dsc_pkg.sv
package sdi_dsc_pkg;
  localparam int unsigned HD_WIDTH = 20;
  localparam int unsigned SD_WIDTH = 10;
  localparam int unsigned POLY_DEG = 9;  // history length, x^9 term
  localparam int unsigned POLY_TAP = 4;  // inner x^4 term
endpackage

// File: rtl/sdi_nrzi_dec.sv
module sdi_nrzi_dec #(
  parameter int unsigned W = 20
) (
  input  logic [W-1:0] rx,
  input  logic         prev_bit,
  output logic [W-1:0] dec
);
  // Bit 0 pairs with the bit carried from the previous word.
  assign dec[0] = rx[0] ^ prev_bit;
  for (genvar i = 1; i < W; i++) begin : g_bit
    assign dec[i] = rx[i] ^ rx[i-1];
  end
endmodule

// File: rtl/sdi_descr_core.sv
module sdi_descr_core #(
  parameter int unsigned W   = 20,
  parameter int unsigned DEG = 9,
  parameter int unsigned TAP = 4,
  localparam int unsigned EW = W + DEG
) (
  input  logic [W-1:0]   dec,
  input  logic [DEG-1:0] hist,   // hist[0] oldest, hist[DEG-1] newest
  output logic [EW-1:0]  ext,
  output logic [W-1:0]   plain
);
  assign ext = {dec, hist};
  // Unrolled recurrence: bit i sits at ext[i+DEG].
  for (genvar i = 0; i < W; i++) begin : g_tap
    assign plain[i] = ext[i+DEG] ^ ext[i+DEG-TAP] ^ ext[i];
  end
endmodule

// File: rtl/sdi_rx_descrambler.sv
module sdi_rx_descrambler
  import sdi_dsc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hd_mode,
  input  logic                din_vld,
  input  logic [HD_WIDTH-1:0] din,
  output logic                dout_vld,
  output logic [HD_WIDTH-1:0] dout
);
  localparam int unsigned W  = HD_WIDTH;
  localparam int unsigned SW = SD_WIDTH;
  localparam int unsigned HL = POLY_DEG;
  localparam int unsigned EW = W + HL;

  logic          prev_q, prev_d;
  logic [HL-1:0] hist_q, hist_d;
  logic [W-1:0]  dout_q, dout_d;
  logic          vld_q;
  logic [W-1:0]  dec, plain;
  logic [EW-1:0] ext;

  sdi_nrzi_dec #(.W(W)) nrzi_i (
    .rx(din), .prev_bit(prev_q), .dec(dec)
  );

  sdi_descr_core #(.W(W), .DEG(HL), .TAP(POLY_TAP)) core_i (
    .dec(dec), .hist(hist_q), .ext(ext), .plain(plain)
  );

  always_comb begin
    prev_d = prev_q;
    hist_d = hist_q;
    dout_d = dout_q;
    if (din_vld) begin
      if (hd_mode) begin
        prev_d = din[W-1];
        hist_d = ext[W+HL-1:W];
        dout_d = plain;
      end else begin
        prev_d = din[SW-1];
        hist_d = ext[SW+HL-1:SW];
        dout_d = {{(W-SW){1'b0}}, plain[SW-1:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hist_q <= '0;
      dout_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= din_vld;
      if (din_vld) begin
        prev_q <= prev_d;
        hist_q <= hist_d;
        dout_q <= dout_d;
      end
    end
  end

  assign dout     = dout_q;
  assign dout_vld = vld_q;

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    din_vld |=> dout_vld);
  // R2
  vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !din_vld |=> !dout_vld);
  // R6
  sd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (din_vld && !hd_mode) |=> (dout[W-1:SW] == '0));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !din_vld |=> ($stable(dout) && $stable(hist_q) && $stable(prev_q)));
endmodule

// File: tb/sdi_rx_descrambler_tb.sv
module sdi_rx_descrambler_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hd_mode = 1'b1;
  logic        din_vld = 1'b0;
  logic [19:0] din = '0;
  logic        dout_vld;
  logic [19:0] dout;

  int checks = 0;
  int errors = 0;

  // reference state: m_h[0] newest decoded bit
  logic       m_prev;
  logic [8:0] m_h;
  logic [19:0] exp_d;

  always #5 clk = ~clk;

  sdi_rx_descrambler dut_i (
    .clk(clk), .rst_n(rst_n), .hd_mode(hd_mode), .din_vld(din_vld),
    .din(din), .dout_vld(dout_vld), .dout(dout)
  );

  // {hd, vld, data}
  localparam int NV = 18;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 1'b1, 20'h00000}, {1'b1, 1'b1, 20'hFFFFF},
    {1'b1, 1'b1, 20'hA5A5A}, {1'b1, 1'b1, 20'h3FF00},
    {1'b1, 1'b0, 20'h12345}, {1'b0, 1'b1, 20'hFC3FF},
    {1'b0, 1'b1, 20'h00155}, {1'b0, 1'b1, 20'hAB2AA},
    {1'b0, 1'b0, 20'hFFFFF}, {1'b1, 1'b1, 20'h0F0F0},
    {1'b1, 1'b1, 20'h80001}, {1'b0, 1'b1, 20'h55200},
    {1'b1, 1'b0, 20'h00000}, {1'b1, 1'b1, 20'h7FFFE},
    {1'b1, 1'b1, 20'hC3C3C}, {1'b0, 1'b1, 20'h003FF},
    {1'b0, 1'b1, 20'hFFC00}, {1'b1, 1'b1, 20'h96969}
  };

  task automatic model(input logic hd, input logic [19:0] d);
    int n = hd ? 20 : 10;
    exp_d = '0;
    for (int i = 0; i < n; i++) begin
      logic nb, ob;
      nb = d[i] ^ m_prev;
      m_prev = d[i];
      ob = nb ^ m_h[3] ^ m_h[8];
      m_h = {m_h[7:0], nb};
      exp_d[i] = ob;
    end
  endtask

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  // drive at negedge, check at next negedge
  task automatic step(input logic hd, input logic v, input logic [19:0] d, input string req);
    logic [19:0] hold;
    hold = dout;
    hd_mode = hd; din_vld = v; din = d;
    if (v) model(hd, d);
    @(negedge clk);
    check("R2", {19'b0, dout_vld}, {19'b0, v});
    if (v) check(req, dout, exp_d);
    else   check("R7", dout, hold);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; din_vld = 1'b0;
    m_prev = 1'b0; m_h = '0;
    @(negedge clk); @(negedge clk);
    check("R1", dout, 20'h0);
    check("R1", {19'b0, dout_vld}, 20'h0);
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 R3 R4 R5: hand-derived value after reset
    step(1'b1, 1'b1, 20'hFFFFF, "R1");
    check("R1", dout, 20'h00211);

    // table: R3 R4 R5 R6 R7 R8 with rate switches after idle words
    do_reset();
    for (int k = 0; k < NV; k++) begin
      step(VEC[k][21], VEC[k][20], VEC[k][19:0], VEC[k][21] ? "R4" : "R8");
    end

    // R6: upper bits ignored in SD mode, hand-derived
    do_reset();
    step(1'b0, 1'b1, 20'hFFFFF, "R6");
    check("R6", dout, 20'h00211);
    // R6: bit 9 is the NRZI reference; next all-ones SD word decodes to zeros
    step(1'b0, 1'b1, 20'h003FF, "R3");

    // R7: long idle with junk, then continuation must match model
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 20'hABCDE ^ 20'(k), "R7");
    step(1'b1, 1'b1, 20'h13579, "R7");

    // R5: bit 19 becomes reference for next HD word
    step(1'b1, 1'b1, 20'h80000, "R5");
    step(1'b1, 1'b1, 20'h00001, "R5");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule